// File: doc/BRIEF.md
# Banked Sensor Register File

This block is the register front of a hardware monitor that watches many measurement channels through a small window of byte addresses. A bank-select register picks one channel. Five banked offsets then reach that channel's enable and flag byte, its latest reading, and its high, low and critical limits. A separate sample port delivers new readings from the converter. Each reading that an enabled channel accepts is compared against the channel's limits. An out-of-window reading latches a per-channel event bit.

The event bits are shared, not banked. Software clears them by writing ones. Two masks route the latched events to two interrupt lines: a normal interrupt and a system-management interrupt. A third output, `crit_o`, is a level. It stays high while any enabled channel holds a reading above its critical limit.

One parameter sets the channel count, from 1 to 16. A second parameter selects signed readings, for a temperature build, or unsigned readings, for a voltage build. The defaults give the voltage build with fourteen channels. A temperature build uses three channels with `SIGNED_READ` set.

Top module: `sensbank_regfile`

## Requirements
- R1: After reset, all event, mask, global-configuration, bank and reading registers read 0 and every channel is disabled. The high and critical limits read 0xFF (unsigned build) or 0x7F (signed build). The low limit reads 0x00 (unsigned) or 0x80 (signed). `irq_o`, `smi_o` and `crit_o` are low.
- R2: Offset 0x09 holds the bank number and reads back as written. Offsets 0x0A to 0x0E reach the channel it names. If the bank number is not below the channel count, those offsets read 0 and writes to them are dropped.
- R3: Offset 0x0A bit 0 is the channel enable and can be read and written. Three bits are read-only live flags on the stored reading: bit 1 is set when the reading is above the high limit, bit 2 when it is below the low limit, and bit 3 when it is above the critical limit. Bits 7:4 read 0.
- R4: A `smp_valid` cycle aimed at an enabled channel stores `smp_value` as that channel's reading, which is then read at offset 0x0B. Bus writes to 0x0B are ignored.
- R5: A sample for a disabled channel, or for a channel number not below the channel count, changes no reading and sets no event bit.
- R6: An accepted sample sets that channel's event bit when it is strictly above the high limit (offset 0x0C) or strictly below the low limit (offset 0x0D). A sample equal to either limit raises nothing. Comparisons are two's-complement when `SIGNED_READ` is 1 and unsigned otherwise.
- R7: Event bit i is at offset 0x00 bit i for channels 0 to 7, and at offset 0x01 bit i-8 for channels 8 to 15. Writing 1 to a bit clears it and writing 0 has no effect. A new event in the same cycle as its clear leaves the bit set.
- R8: `irq_o` is high when any event bit is set whose interrupt-mask bit is set (offsets 0x04/0x05, same bit layout as R7). `smi_o` is formed the same way from the mask at offsets 0x02/0x03.
- R9: `crit_o` is high while any enabled channel's stored reading is above its critical limit (offset 0x0E).
- R10: Offset 0x08 is an 8-bit global configuration byte that can be read and written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, commits on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| smp_valid | input | 1 | New reading present on the sample port |
| smp_chan | input | CH_W | Channel the reading belongs to |
| smp_value | input | 8 | The reading |
| irq_o | output | 1 | Masked OR of events, interrupt route |
| smi_o | output | 1 | Masked OR of events, management route |
| crit_o | output | 1 | Some enabled channel is above its critical limit |

## Verification
The assertions check the following on every cycle:
- An event bit never rises without a sample in the previous cycle.
- An all-ones write to the low status byte, with no sample present, empties that byte.
- Neither interrupt line is high while the status is empty or its mask is zero.
- The bank number changes only when offset 0x09 is written.

The scenarios must show the rest:
- Strict-versus-equal limit boundaries.
- Signed against unsigned ordering.
- Priority of a new event over a same-cycle clear.
- Dropped writes to an out-of-range bank.
- Samples ignored by disabled channels.
- `crit_o` following the enable and critical limit.

// File: rtl/sensbank_pkg.sv
package sensbank_pkg;

  localparam int DW = 8;

  // Register offsets; bank-select sits before the banked window.
  localparam logic [3:0] A_EVSTAT = 4'h0;
  localparam logic [3:0] A_EVSMI  = 4'h2;
  localparam logic [3:0] A_EVIRQ  = 4'h4;
  localparam logic [3:0] A_GCFG   = 4'h8;
  localparam logic [3:0] A_BANK   = 4'h9;
  localparam logic [3:0] A_CHCFG  = 4'hA;
  localparam logic [3:0] A_READ   = 4'hB;
  localparam logic [3:0] A_HI     = 4'hC;
  localparam logic [3:0] A_LO     = 4'hD;
  localparam logic [3:0] A_OT     = 4'hE;

  typedef struct packed {
    logic          en;
    logic [DW-1:0] reading;
    logic [DW-1:0] hi;
    logic [DW-1:0] lo;
    logic [DW-1:0] ot;
  } chan_view_t;

  // a strictly greater than b, in the build's number format
  function automatic logic exceeds(input logic [DW-1:0] a,
                                   input logic [DW-1:0] b,
                                   input logic sgn);
    if (sgn) return $signed(a) > $signed(b);
    return a > b;
  endfunction

  // channel config/status byte: live flags over the stored reading
  function automatic logic [DW-1:0] cfg_byte(input chan_view_t c, input logic sgn);
    return {4'b0000,
            exceeds(c.reading, c.ot, sgn),
            exceeds(c.lo, c.reading, sgn),
            exceeds(c.reading, c.hi, sgn),
            c.en};
  endfunction

  // byte k of a 16-bit vector
  function automatic logic [DW-1:0] byte_of(input logic [15:0] v, input int k);
    return v[k*DW +: DW];
  endfunction

endpackage

// File: rtl/sensbank_chan.sv
module sensbank_chan
  import sensbank_pkg::*;
#(
  parameter bit            SIGNED_READ = 1'b0,
  parameter logic [DW-1:0] HI_RST      = 8'hFF,
  parameter logic [DW-1:0] LO_RST      = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  logic [3:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          smp_hit,
  input  logic [DW-1:0] smp_value,
  output chan_view_t    view,
  output logic          evt_set,
  output logic          crit
);

  logic          en_q;
  logic [DW-1:0] rd_q, hi_q, lo_q, ot_q;
  logic          smp_ok;

  assign smp_ok  = smp_hit && en_q;
  assign evt_set = smp_ok && (exceeds(smp_value, hi_q, SIGNED_READ) ||
                              exceeds(lo_q, smp_value, SIGNED_READ));
  assign crit    = en_q && exceeds(rd_q, ot_q, SIGNED_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      rd_q <= '0;
      hi_q <= HI_RST;
      lo_q <= LO_RST;
      ot_q <= HI_RST;
    end else begin
      if (sel_wr) begin
        case (addr)
          A_CHCFG: en_q <= wdata[0];
          A_HI:    hi_q <= wdata;
          A_LO:    lo_q <= wdata;
          A_OT:    ot_q <= wdata;
          default: ;
        endcase
      end
      if (smp_ok) rd_q <= smp_value;
    end
  end

  assign view = '{en: en_q, reading: rd_q, hi: hi_q, lo: lo_q, ot: ot_q};

endmodule

// File: rtl/sensbank_evt.sv
module sensbank_evt
  import sensbank_pkg::*;
#(
  parameter int NUM_CH = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [NUM_CH-1:0] set_vec,
  output logic [NUM_CH-1:0] status,
  output logic [NUM_CH-1:0] smi_mask,
  output logic [NUM_CH-1:0] irq_mask,
  output logic              irq_o,
  output logic              smi_o
);

  logic [NUM_CH-1:0] clr_vec, stat_n, smi_n, irq_n;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      clr_vec[i] = bus_wr && (bus_addr == A_EVSTAT + 4'(i / DW)) && bus_wdata[i % DW];
      smi_n[i]   = (bus_wr && bus_addr == A_EVSMI + 4'(i / DW)) ? bus_wdata[i % DW] : smi_mask[i];
      irq_n[i]   = (bus_wr && bus_addr == A_EVIRQ + 4'(i / DW)) ? bus_wdata[i % DW] : irq_mask[i];
    end
    // a fresh event outranks a clear in the same cycle
    stat_n = set_vec | (status & ~clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      smi_mask <= '0;
      irq_mask <= '0;
    end else begin
      status   <= stat_n;
      smi_mask <= smi_n;
      irq_mask <= irq_n;
    end
  end

  assign irq_o = |(status & irq_mask);
  assign smi_o = |(status & smi_mask);

endmodule

// File: rtl/sensbank_regfile.sv
module sensbank_regfile
  import sensbank_pkg::*;
#(
  parameter int  NUM_CH      = 14,
  parameter bit  SIGNED_READ = 1'b0,
  localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            smp_valid,
  input  logic [CH_W-1:0] smp_chan,
  input  logic [DW-1:0]   smp_value,
  output logic            irq_o,
  output logic            smi_o,
  output logic            crit_o
);

  localparam logic [DW-1:0] HI_RST = SIGNED_READ ? 8'h7F : 8'hFF;
  localparam logic [DW-1:0] LO_RST = SIGNED_READ ? 8'h80 : 8'h00;

  logic [DW-1:0]     gcfg_q;
  logic [DW-1:0]     bank_sel;
  chan_view_t        views [NUM_CH];
  logic [NUM_CH-1:0] bank_hit, evt_set_vec, crit_vec;
  logic [NUM_CH-1:0] evt_status, smi_mask_q, irq_mask_q;
  chan_view_t        sel_view;
  logic              bank_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcfg_q   <= '0;
      bank_sel <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_GCFG) gcfg_q   <= bus_wdata;
      if (bus_addr == A_BANK) bank_sel <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign bank_hit[g] = (bank_sel == 8'(g));
    sensbank_chan #(
      .SIGNED_READ(SIGNED_READ), .HI_RST(HI_RST), .LO_RST(LO_RST)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr   (bus_wr && bank_hit[g]),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .smp_hit  (smp_valid && (smp_chan == CH_W'(g))),
      .smp_value(smp_value),
      .view     (views[g]),
      .evt_set  (evt_set_vec[g]),
      .crit     (crit_vec[g])
    );
  end

  sensbank_evt #(.NUM_CH(NUM_CH)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .set_vec  (evt_set_vec),
    .status   (evt_status),
    .smi_mask (smi_mask_q),
    .irq_mask (irq_mask_q),
    .irq_o    (irq_o),
    .smi_o    (smi_o)
  );

  assign crit_o  = |crit_vec;
  assign bank_ok = |bank_hit;

  always_comb begin
    sel_view = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (bank_hit[i]) sel_view = views[i];
  end

  always_comb begin
    case (bus_addr)
      A_EVSTAT:        bus_rdata = byte_of(16'(evt_status), 0);
      A_EVSTAT + 4'd1: bus_rdata = byte_of(16'(evt_status), 1);
      A_EVSMI:         bus_rdata = byte_of(16'(smi_mask_q), 0);
      A_EVSMI + 4'd1:  bus_rdata = byte_of(16'(smi_mask_q), 1);
      A_EVIRQ:         bus_rdata = byte_of(16'(irq_mask_q), 0);
      A_EVIRQ + 4'd1:  bus_rdata = byte_of(16'(irq_mask_q), 1);
      A_GCFG:          bus_rdata = gcfg_q;
      A_BANK:          bus_rdata = bank_sel;
      A_CHCFG:         bus_rdata = bank_ok ? cfg_byte(sel_view, SIGNED_READ) : '0;
      A_READ:          bus_rdata = sel_view.reading;
      A_HI:            bus_rdata = sel_view.hi;
      A_LO:            bus_rdata = sel_view.lo;
      A_OT:            bus_rdata = sel_view.ot;
      default:         bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sensbank_chk.sv
module sensbank_chk
  import sensbank_pkg::*;
#(
  parameter int NUM_CH = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        bus_addr,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_wdata,
  input logic              smp_valid,
  input logic [NUM_CH-1:0] status,
  input logic [NUM_CH-1:0] irq_mask,
  input logic [NUM_CH-1:0] smi_mask,
  input logic [DW-1:0]     bank_sel,
  input logic              irq_o,
  input logic              smi_o
);

  localparam int LOW_N = (NUM_CH < DW) ? NUM_CH : DW;
  localparam logic [NUM_CH-1:0] LOW_MASK = NUM_CH'((33'd1 << LOW_N) - 33'd1);

  // R5
  evt_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & ~$past(status))) |-> $past(smp_valid));

  // R7
  w1c_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EVSTAT && bus_wdata == 8'hFF && !smp_valid)
      |=> ((status & LOW_MASK) == '0));

  // R8
  quiet_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> (!irq_o && !smi_o));

  // R8
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq_o);

  // R8
  smi_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_mask == '0) |-> !smi_o);

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_BANK) |=> $stable(bank_sel));

endmodule

bind sensbank_regfile sensbank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .smp_valid(smp_valid),
  .status   (evt_status),
  .irq_mask (irq_mask_q),
  .smi_mask (smi_mask_q),
  .bank_sel (bank_sel),
  .irq_o    (irq_o),
  .smi_o    (smi_o)
);

// File: tb/sensbank_regfile_tb.sv
module sensbank_regfile_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // voltage build (defaults)
  logic [3:0] m_addr = '0;
  logic       m_wr = 1'b0;
  logic [7:0] m_wdata = '0, m_rdata;
  logic       m_sv = 1'b0;
  logic [3:0] m_sch = '0;
  logic [7:0] m_sval = '0;
  logic       m_irq, m_smi, m_crit;

  // temperature build
  logic [3:0] t_addr = '0;
  logic       t_wr = 1'b0;
  logic [7:0] t_wdata = '0, t_rdata;
  logic       t_sv = 1'b0;
  logic [1:0] t_sch = '0;
  logic [7:0] t_sval = '0;
  logic       t_irq, t_smi, t_crit;

  sensbank_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(m_addr), .bus_wr(m_wr),
    .bus_wdata(m_wdata), .bus_rdata(m_rdata), .smp_valid(m_sv),
    .smp_chan(m_sch), .smp_value(m_sval), .irq_o(m_irq), .smi_o(m_smi),
    .crit_o(m_crit));

  sensbank_regfile #(.NUM_CH(3), .SIGNED_READ(1'b1)) u_dut_t (
    .clk(clk), .rst_n(rst_n), .bus_addr(t_addr), .bus_wr(t_wr),
    .bus_wdata(t_wdata), .bus_rdata(t_rdata), .smp_valid(t_sv),
    .smp_chan(t_sch), .smp_value(t_sval), .irq_o(t_irq), .smi_o(t_smi),
    .crit_o(t_crit));

  // kinds: 0 main rdata, 1 irq, 2 smi, 3 crit, 4 temp rdata
  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.kind)
        0: act = m_rdata;
        1: act = {7'b0, m_irq};
        2: act = {7'b0, m_smi};
        3: act = {7'b0, m_crit};
        default: act = t_rdata;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input bit tgt, input logic [3:0] a, input logic [7:0] d);
    if (!tgt) begin m_addr = a; m_wr = 1'b1; m_wdata = d; end
    else      begin t_addr = a; t_wr = 1'b1; t_wdata = d; end
    step();
    m_wr = 1'b0; t_wr = 1'b0;
  endtask

  task automatic smp(input bit tgt, input logic [3:0] ch, input logic [7:0] v);
    if (!tgt) begin m_sv = 1'b1; m_sch = ch; m_sval = v; end
    else      begin t_sv = 1'b1; t_sch = ch[1:0]; t_sval = v; end
    step();
    m_sv = 1'b0; t_sv = 1'b0;
  endtask

  task automatic smp_wr(input logic [3:0] ch, input logic [7:0] v,
                        input logic [3:0] a, input logic [7:0] d);
    m_sv = 1'b1; m_sch = ch; m_sval = v;
    m_addr = a; m_wr = 1'b1; m_wdata = d;
    step();
    m_sv = 1'b0; m_wr = 1'b0;
  endtask

  task automatic rd(input bit tgt, input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    if (!tgt) m_addr = a; else t_addr = a;
    it.kind = tgt ? 4 : 0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    step();
  endtask

  task automatic chk(input int kind, input logic e, input string tag);
    item_t it;
    it.kind = kind; it.exp = {7'b0, e}; it.tag = tag;
    sbq.push_back(it);
    step();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    rd(0, 4'h0, 8'h00, "R1 status lo");
    rd(0, 4'h1, 8'h00, "R1 status hi");
    rd(0, 4'h9, 8'h00, "R1 bank");
    rd(0, 4'hA, 8'h00, "R1 cfg");
    rd(0, 4'hC, 8'hFF, "R1 high");
    rd(0, 4'hD, 8'h00, "R1 low");
    rd(0, 4'hE, 8'hFF, "R1 crit lim");
    chk(1, 1'b0, "R1 irq");
    chk(2, 1'b0, "R1 smi");
    chk(3, 1'b0, "R1 crit");
    rd(1, 4'hC, 8'h7F, "R1 signed high");
    rd(1, 4'hD, 8'h80, "R1 signed low");
    rd(1, 4'hA, 8'h00, "R1 signed cfg");

    // R10 global config
    wr(0, 4'h8, 8'h5A);
    rd(0, 4'h8, 8'h5A, "R10 gcfg");
    wr(0, 4'h8, 8'h00);
    rd(0, 4'h8, 8'h00, "R10 gcfg zero");

    // R2/R3 bank 3 setup
    wr(0, 4'h9, 8'h03);
    rd(0, 4'h9, 8'h03, "R2 bank readback");
    wr(0, 4'hA, 8'h01);
    wr(0, 4'hC, 8'hC0);
    wr(0, 4'hD, 8'h40);
    wr(0, 4'hE, 8'hE0);
    rd(0, 4'hA, 8'h05, "R3 en+below");

    // R4 in-window sample
    smp(0, 4'd3, 8'h80);
    rd(0, 4'hB, 8'h80, "R4 reading");
    rd(0, 4'hA, 8'h01, "R3 in window");
    rd(0, 4'h0, 8'h00, "R6 no event");

    // R6 above high
    smp(0, 4'd3, 8'hC1);
    rd(0, 4'h0, 8'h08, "R6 event ch3");
    rd(0, 4'hA, 8'h03, "R3 above flag");
    chk(1, 1'b0, "R8 irq unmasked");
    wr(0, 4'h4, 8'h08);
    chk(1, 1'b1, "R8 irq routed");
    chk(2, 1'b0, "R8 smi not routed");

    // R7 channel 10 lands in byte 1
    wr(0, 4'h9, 8'h0A);
    wr(0, 4'hA, 8'h01);
    wr(0, 4'hD, 8'h20);
    smp(0, 4'd10, 8'h10);
    rd(0, 4'h1, 8'h04, "R7 ch10 bit");
    rd(0, 4'h0, 8'h08, "R7 byte0 kept");
    chk(2, 1'b0, "R8 smi before mask");
    wr(0, 4'h3, 8'h04);
    chk(2, 1'b1, "R8 smi routed");

    // R5 disabled and out-of-range samples
    smp(0, 4'd5, 8'hFF);
    rd(0, 4'h0, 8'h08, "R5 disabled no event");
    rd(0, 4'h1, 8'h04, "R5 disabled no event hi");
    wr(0, 4'h9, 8'h05);
    rd(0, 4'hB, 8'h00, "R5 disabled reading");
    rd(0, 4'hA, 8'h00, "R3 disabled cfg");
    smp(0, 4'd15, 8'hFF);
    rd(0, 4'h0, 8'h08, "R5 out of range chan");

    // R7 write-one-to-clear
    wr(0, 4'h0, 8'h00);
    rd(0, 4'h0, 8'h08, "R7 zero write");
    wr(0, 4'h0, 8'h08);
    rd(0, 4'h0, 8'h00, "R7 cleared");
    chk(1, 1'b0, "R8 irq drops");
    chk(2, 1'b1, "R8 smi holds");
    wr(0, 4'h1, 8'h04);
    chk(2, 1'b0, "R8 smi drops");
    rd(0, 4'h1, 8'h00, "R7 cleared hi");

    // R7 set wins over clear
    smp_wr(4'd3, 8'hFF, 4'h0, 8'h08);
    rd(0, 4'h0, 8'h08, "R7 set beats clear");
    chk(3, 1'b1, "R9 crit high");
    chk(1, 1'b1, "R8 irq again");

    // R6 equality boundaries
    wr(0, 4'h0, 8'h08);
    smp(0, 4'd3, 8'h40);
    rd(0, 4'h0, 8'h00, "R6 equal low");
    smp(0, 4'd3, 8'hC0);
    rd(0, 4'h0, 8'h00, "R6 equal high");
    chk(3, 1'b0, "R9 crit low");

    // R4 read-only reading
    wr(0, 4'h9, 8'h03);
    wr(0, 4'hB, 8'h33);
    rd(0, 4'hB, 8'hC0, "R4 write ignored");

    // R2 out-of-range bank
    wr(0, 4'h9, 8'h14);
    rd(0, 4'h9, 8'h14, "R2 bank 20");
    rd(0, 4'hB, 8'h00, "R2 oor read");
    wr(0, 4'hC, 8'h11);
    wr(0, 4'h9, 8'h03);
    rd(0, 4'hC, 8'hC0, "R2 oor write dropped");

    // R9 crit follows limit and enable
    wr(0, 4'hE, 8'h10);
    chk(3, 1'b1, "R9 crit by limit");
    rd(0, 4'hA, 8'h09, "R3 crit flag");
    wr(0, 4'hA, 8'h00);
    chk(3, 1'b0, "R9 crit needs enable");

    // R6 signed build
    wr(1, 4'h9, 8'h02);
    wr(1, 4'hA, 8'h01);
    wr(1, 4'hC, 8'h10);
    wr(1, 4'hD, 8'hF6);
    smp(1, 4'd2, 8'hFB);
    rd(1, 4'h0, 8'h00, "R6 signed in window");
    smp(1, 4'd2, 8'hF0);
    rd(1, 4'h0, 8'h04, "R6 signed below");
    rd(1, 4'hB, 8'hF0, "R4 signed reading");
    rd(1, 4'hA, 8'h05, "R3 signed flags");
    rd(1, 4'h1, 8'h00, "R7 no high byte");

    step();
    step();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule